// File: doc/BRIEF.md
# Cascaded Modulo-5 Two-Digit Counter

This block is a two-digit up-counter in which each digit is a 3-bit value that counts 0 to 4 and then wraps. The low digit advances on every rising clock edge on which the count-enable input is high. The high digit advances only on the edge where the low digit wraps from 4 back to 0. Together the two digits step through 25 states, from 00 to 44, and then return to 00.

Both digits are built from the same digit-counter module. A separate piece of combinational glue next to the digit instances produces the carry. The carry is the shared enable ANDed with "low digit equals 4", and it drives the enable of the upper digit. Reset is synchronous and active low. A low reset seen at a rising edge clears both digits, whatever the enable input is doing.

Top module: `cascade_mod5_pair`

## Requirements
- R1: On a rising clock edge with rst_ni low, both digits become 0, whether en_i is high or low.
- R2: On a rising edge with rst_ni high and en_i low, both digits keep their values.
- R3: On a rising edge with rst_ni high and en_i high, the low digit moves to (value+1) mod 5, following the sequence 0,1,2,3,4,0.
- R4: The high digit changes only on a rising edge where rst_ni is high, en_i is high and the low digit is 4. On that edge it moves to (value+1) mod 5.
- R5: Neither digit ever holds 5, 6 or 7 after a reset.
- R6: Starting from 00 with en_i held high, the pair returns to 00 after exactly 25 enabled edges. The high digit wraps from 4 to 0 on the edge that takes 44 to 00.
- R7: Holding en_i low while the low digit is 4 leaves both digits unchanged. The high digit advances only once, on the first enabled edge after the hold.
- R8: Reset is synchronous. Driving rst_ni low between edges leaves both outputs unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state changes only on its rising edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Count enable for the cascade |
| q_hi_o | output | 3 | Most significant digit, 0 to 4 |
| q_lo_o | output | 3 | Least significant digit, 0 to 4 |

## Verification
The bound checker checks these rules on every edge: the clearing effect of reset, holding when the enable is low, the modulo-5 step of each digit, and that the high digit never moves without a carry. It also checks that no digit leaves the 0 to 4 range. Some behaviour only shows up over a sequence of cycles, so the bench's scenarios are needed for it. That covers the full 25-state cycle returning to 00, a hold with the low digit parked at 4 followed by exactly one carry, and reset taking effect at the next edge rather than when rst_ni falls. The bench's behavioural model is compared against both outputs after every edge.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
  localparam int unsigned DIGIT_MOD = 5;
  localparam int unsigned DIGIT_W   = $clog2(DIGIT_MOD);
  localparam int unsigned NUM_DIG   = 2;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/mod_digit.sv
module mod_digit #(
  parameter int unsigned MOD = 5,
  parameter int unsigned W   = $clog2(MOD)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     q_o <= '0;
    else if (en_i)   q_o <= (q_o == LAST) ? '0 : q_o + W'(1);
  end
endmodule

// File: rtl/roll_glue.sv
// Carry chain between digits.
//   en_i  digit[k-1]==LAST | en_o[k]
//   0     x                | 0
//   1     0                | 0
//   1     1                | 1
module roll_glue #(
  parameter int unsigned N   = 2,
  parameter int unsigned MOD = 5,
  parameter int unsigned W   = $clog2(MOD)
) (
  input  logic                en_i,
  input  logic [N-1:0][W-1:0] digits_i,
  output logic [N-1:0]        en_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  assign en_o[0] = en_i;
  for (genvar k = 1; k < N; k++) begin : g_chain
    assign en_o[k] = en_o[k-1] & (digits_i[k-1] == LAST);
  end
endmodule

// File: rtl/cascade_mod5_pair.sv
module cascade_mod5_pair
  import cascade_pkg::*;
#(
  parameter int unsigned MOD = DIGIT_MOD,
  parameter int unsigned W   = $clog2(MOD)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] q_hi_o,
  output logic [W-1:0] q_lo_o
);
  localparam int unsigned N = NUM_DIG;

  logic [N-1:0][W-1:0] digits;
  logic [N-1:0]        dig_en;

  roll_glue #(.N(N), .MOD(MOD), .W(W)) i_glue (
    .en_i     (en_i),
    .digits_i (digits),
    .en_o     (dig_en)
  );

  for (genvar k = 0; k < N; k++) begin : g_digit
    mod_digit #(.MOD(MOD), .W(W)) i_digit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (dig_en[k]),
      .q_o    (digits[k])
    );
  end

  assign q_lo_o = digits[0];
  assign q_hi_o = digits[N-1];
endmodule

// File: rtl/cascade_mod5_pair_checker.sv
module cascade_mod5_pair_checker #(
  parameter int unsigned MOD = 5,
  parameter int unsigned W   = $clog2(MOD)
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         roll_i,
  input logic [W-1:0] q_hi_i,
  input logic [W-1:0] q_lo_i
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  a_r1_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |=> (q_hi_i == '0 && q_lo_i == '0));

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(q_lo_i) && $stable(q_hi_i)));

  a_r3_lo_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> q_lo_i == (($past(q_lo_i) == LAST) ? W'(0) : $past(q_lo_i) + W'(1)));

  a_r4_hi_stable_without_roll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !roll_i |=> $stable(q_hi_i));

  a_r4_hi_step_on_roll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_i |=> q_hi_i == (($past(q_hi_i) == LAST) ? W'(0) : $past(q_hi_i) + W'(1)));

  a_r4_roll_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    roll_i |-> (en_i && q_lo_i == LAST));

  a_r5_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (q_lo_i <= LAST && q_hi_i <= LAST));
endmodule

bind cascade_mod5_pair cascade_mod5_pair_checker #(.MOD(MOD), .W(W)) i_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .roll_i (dig_en[1]),
  .q_hi_i (q_hi_o),
  .q_lo_i (q_lo_o)
);

// File: tb/test_cascade_mod5_pair.sv
`timescale 1ns/1ps
module test_cascade_mod5_pair;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [2:0] q_hi_o, q_lo_o;

  int tests = 0, fails = 0;
  int m_hi = 0, m_lo = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  cascade_mod5_pair i_cascade_mod5_pair (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (en_i),
    .q_hi_o (q_hi_o), .q_lo_o (q_lo_o)
  );

  task automatic check(string tag, int exp_hi, int exp_lo);
    tests++;
    if (q_hi_o !== 3'(exp_hi) || q_lo_o !== 3'(exp_lo)) begin
      fails++;
      $display("FAIL %s: got hi=%0d lo=%0d expected hi=%0d lo=%0d",
               tag, q_hi_o, q_lo_o, exp_hi, exp_lo);
    end
  endtask

  task automatic check_range(string tag);
    tests++;
    if (q_hi_o > 3'd4 || q_lo_o > 3'd4) begin
      fails++;
      $display("FAIL %s: got hi=%0d lo=%0d expected both <= 4", tag, q_hi_o, q_lo_o);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(bit rst_n, bit en, string tag);
    rst_ni = rst_n;
    en_i   = en;
    @(posedge clk_i);
    if (!rst_n) begin
      m_hi = 0; m_lo = 0;
    end else if (en) begin
      if (m_lo == 4) begin
        m_lo = 0;
        m_hi = (m_hi + 1) % 5;
      end else m_lo = m_lo + 1;
    end
    @(negedge clk_i);
    check(tag, m_hi, m_lo);
    check_range("R5 range");
  endtask

  initial begin
    @(negedge clk_i);
    step(0, 0, "R1 reset en low");
    step(0, 1, "R1 reset en high");
    check("R1 reset state", 0, 0);

    // R3 low digit sequence, R4 first carry
    for (int i = 0; i < 7; i++) step(1, 1, "R3 count");
    check("R4 carry to 12", 1, 2);

    // R2 hold at arbitrary value
    for (int i = 0; i < 3; i++) step(1, 0, "R2 hold");
    check("R2 held 12", 1, 2);

    // R7 park low digit at 4 and hold
    step(1, 1, "R3 count"); step(1, 1, "R3 count");
    check("R7 parked at 14", 1, 4);
    step(1, 0, "R7 hold at 4");
    step(1, 0, "R7 hold at 4");
    check("R7 no advance during hold", 1, 4);
    step(1, 1, "R7 single carry");
    check("R7 carry after hold", 2, 0);

    // R8 synchronous reset: drop between edges
    rst_ni = 1'b0;
    #5;
    check("R8 no change before edge", 2, 0);
    @(posedge clk_i);
    m_hi = 0; m_lo = 0;
    @(negedge clk_i);
    check("R8 cleared at edge", 0, 0);

    // R6 full wrap from 00
    for (int i = 0; i < 24; i++) step(1, 1, "R6 sweep");
    check("R6 reached 44", 4, 4);
    step(1, 1, "R6 wrap");
    check("R6 back to 00", 0, 0);

    // mixed enable pattern against model
    for (int i = 0; i < 40; i++) step(1, (i % 3) != 1, "R4 mixed pattern");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule